// File: doc/BRIEF.md
# Dual-Lane SIMD Register File with Shadow Banks

This block holds the general-purpose data registers for two processing lanes that run in lockstep. Each lane has 16 architectural registers, 40 bits wide, so a register can carry extended-precision values. Every register has two copies, a primary and a secondary. A single bank selector, shared by both lanes, chooses which copy is live. An interrupt handler can therefore swap the whole working set in one write and later restore it, without saving anything to memory.

Lane X is always active. Lane Y takes part only while SIMD mode is on. In that mode a single register index acts on the same register in both lanes, and each lane supplies or receives its own data. The block serves two compute read ports and one compute write port. It also has a bus transfer port that reads and writes one register index per access. That port moves a single 40-bit value when SIMD mode is off and a pair of values, one per lane, when it is on. The mode bits sit in a small register inside the block. A write to that register takes effect from the next clock cycle.

Top module: `dual_lane_rf`

## Requirements
- R1: While rst_n is low, and after it is released, every register in both banks of both lanes reads zero, simd_on is 0 and alt_bank_on is 0 (primary bank).
- R2: When mode_we is high at a rising edge, simd_on and alt_bank_on take the values of mode_simd_d and mode_alt_d from the next cycle on. Without mode_we they hold. A register access in the same cycle as the mode write still uses the old mode.
- R3: A compute write (cw_en) stores cw_xdata into lane X register cw_idx of the active bank at the rising edge. A read of that register returns the new value from the next cycle.
- R4: Reads are combinational from the active bank. A read of a register that is written in the same cycle returns the value it held before that write.
- R5: While SIMD mode is off, writes to lane Y are ignored, and rd0_ydata, rd1_ydata and the upper half of bus_rdata read zero.
- R6: While SIMD mode is on, a compute write stores cw_xdata into lane X and cw_ydata into lane Y at the same index cw_idx, and the read ports return both lanes' values for their index.
- R7: The bus port packs lane X in bus bits [39:0] and lane Y in bits [79:40]. A bus write stores the low half into lane X always, and the high half into lane Y only in SIMD mode. bus_rdata returns register bus_idx in the same packing.
- R8: If the compute port and the bus port write the same register in the same cycle, the bus port (the higher-numbered write port) wins in each lane.
- R9: Writes go only to the active bank. The inactive bank keeps its contents, and they read back unchanged after the bank is switched back.
- R10: The bank selector is shared, so switching it changes the live bank of lane X and lane Y together.
- R11: The compute and bus ports may write different registers in the same cycle, and both writes land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_simd_d | input | 1 | New SIMD-mode value (1 = lane Y enabled) |
| mode_alt_d | input | 1 | New bank value (1 = secondary bank) |
| simd_on | output | 1 | Current SIMD mode |
| alt_bank_on | output | 1 | Current bank (1 = secondary) |
| cw_en | input | 1 | Compute write enable |
| cw_idx | input | 4 | Compute write register index |
| cw_xdata | input | 40 | Compute write data for lane X |
| cw_ydata | input | 40 | Compute write data for lane Y |
| rd0_idx | input | 4 | Read port 0 register index |
| rd1_idx | input | 4 | Read port 1 register index |
| rd0_xdata | output | 40 | Read port 0, lane X |
| rd0_ydata | output | 40 | Read port 0, lane Y (zero when SIMD is off) |
| rd1_xdata | output | 40 | Read port 1, lane X |
| rd1_ydata | output | 40 | Read port 1, lane Y (zero when SIMD is off) |
| bus_we | input | 1 | Bus port write enable |
| bus_idx | input | 4 | Bus port register index (read and write) |
| bus_wdata | input | 80 | Bus write data: lane Y in [79:40], lane X in [39:0] |
| bus_rdata | output | 80 | Bus read data in the same packing |

## Verification
Two pairs of events can share a clock cycle. The first pair is a compute write and a bus write to the same register, where the bus port must win in each lane. The second pair is a mode write together with a register write or read, where the access must still use the old bank and SIMD setting. The directed sequence sets up both cases on purpose. A random phase then uses a narrow index range, so that collisions, reads during writes and mode changes keep overlapping. The bench keeps a behavioural model of both lanes and both banks. It compares every read port, the bus read data and the mode outputs with that model before each clock edge.

// File: rtl/dual_lane_rf_pkg.sv
package dual_lane_rf_pkg;

  typedef enum logic {
    BANK_PRI = 1'b0,
    BANK_SEC = 1'b1
  } bank_e;

  typedef struct packed {
    logic  simd;
    bank_e bank;
  } rf_mode_t;

endpackage

// File: rtl/dual_lane_rf_mode.sv
module dual_lane_rf_mode
  import dual_lane_rf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_we,
  input  logic     simd_d,
  input  logic     alt_d,
  output rf_mode_t mode_q
);

  rf_mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) begin
      mode_d.simd = simd_d;
      mode_d.bank = alt_d ? BANK_SEC : BANK_PRI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{simd: 1'b0, bank: BANK_PRI};
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/dual_lane_rf_lane.sv
module dual_lane_rf_lane #(
  parameter  int DW    = 40,
  parameter  int NREG  = 16,
  localparam int IW    = $clog2(NREG),
  localparam int NBANK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_allow,
  input  logic          bank_sel,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  input  logic [IW-1:0] rc_idx,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  output logic [DW-1:0] rc_data
);

  logic [DW-1:0] cell_q  [NBANK][NREG];
  logic [DW-1:0] cell_d  [NBANK][NREG];
  logic          cell_en [NBANK][NREG];

  // next-state: port b outranks port a on the same cell
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      for (int r = 0; r < NREG; r++) begin
        cell_en[b][r] = wr_allow && (bank_sel == 1'(b)) &&
                        ((wa_en && (wa_idx == IW'(r))) ||
                         (wb_en && (wb_idx == IW'(r))));
        cell_d[b][r]  = (wb_en && (wb_idx == IW'(r))) ? wb_data : wa_data;
      end
    end
  end

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    for (genvar gr = 0; gr < NREG; gr++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q[gb][gr] <= '0;
        end else if (cell_en[gb][gr]) begin
          cell_q[gb][gr] <= cell_d[gb][gr];
        end
      end
    end
  end

  assign ra_data = cell_q[bank_sel][ra_idx];
  assign rb_data = cell_q[bank_sel][rb_idx];
  assign rc_data = cell_q[bank_sel][rc_idx];

endmodule

// File: rtl/dual_lane_rf.sv
module dual_lane_rf
  import dual_lane_rf_pkg::*;
#(
  parameter  int DW    = 40,
  parameter  int NREG  = 16,
  localparam int IW    = $clog2(NREG),
  localparam int NLANE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              mode_simd_d,
  input  logic              mode_alt_d,
  output logic              simd_on,
  output logic              alt_bank_on,
  input  logic              cw_en,
  input  logic [IW-1:0]     cw_idx,
  input  logic [DW-1:0]     cw_xdata,
  input  logic [DW-1:0]     cw_ydata,
  input  logic [IW-1:0]     rd0_idx,
  input  logic [IW-1:0]     rd1_idx,
  output logic [DW-1:0]     rd0_xdata,
  output logic [DW-1:0]     rd0_ydata,
  output logic [DW-1:0]     rd1_xdata,
  output logic [DW-1:0]     rd1_ydata,
  input  logic              bus_we,
  input  logic [IW-1:0]     bus_idx,
  input  logic [2*DW-1:0]   bus_wdata,
  output logic [2*DW-1:0]   bus_rdata
);

  rf_mode_t      mode_q;
  logic          bank_is_sec;
  logic [DW-1:0] lane_cw  [NLANE];
  logic [DW-1:0] lane_r0  [NLANE];
  logic [DW-1:0] lane_r1  [NLANE];
  logic [DW-1:0] lane_rb  [NLANE];
  logic          lane_act [NLANE];

  dual_lane_rf_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_we (mode_we),
    .simd_d  (mode_simd_d),
    .alt_d   (mode_alt_d),
    .mode_q  (mode_q)
  );

  assign bank_is_sec = (mode_q.bank == BANK_SEC);
  assign simd_on     = mode_q.simd;
  assign alt_bank_on = bank_is_sec;

  for (genvar gl = 0; gl < NLANE; gl++) begin : g_lane
    if (gl == 0) begin : g_x
      assign lane_act[gl] = 1'b1;
      assign lane_cw[gl]  = cw_xdata;
    end else begin : g_y
      assign lane_act[gl] = mode_q.simd;
      assign lane_cw[gl]  = cw_ydata;
    end

    dual_lane_rf_lane #(.DW(DW), .NREG(NREG)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_allow (lane_act[gl]),
      .bank_sel (bank_is_sec),
      .wa_en    (cw_en),
      .wa_idx   (cw_idx),
      .wa_data  (lane_cw[gl]),
      .wb_en    (bus_we),
      .wb_idx   (bus_idx),
      .wb_data  (bus_wdata[gl*DW +: DW]),
      .ra_idx   (rd0_idx),
      .rb_idx   (rd1_idx),
      .rc_idx   (bus_idx),
      .ra_data  (lane_r0[gl]),
      .rb_data  (lane_r1[gl]),
      .rc_data  (lane_rb[gl])
    );

    assign bus_rdata[gl*DW +: DW] = lane_act[gl] ? lane_rb[gl] : '0;
  end

  assign rd0_xdata = lane_r0[0];
  assign rd1_xdata = lane_r1[0];
  assign rd0_ydata = lane_act[1] ? lane_r0[1] : '0;
  assign rd1_ydata = lane_act[1] ? lane_r1[1] : '0;

endmodule

// File: rtl/dual_lane_rf_chk.sv
module dual_lane_rf_chk #(
  parameter  int DW   = 40,
  parameter  int NREG = 16,
  localparam int IW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_we,
  input logic            mode_simd_d,
  input logic            mode_alt_d,
  input logic            simd_on,
  input logic            alt_bank_on,
  input logic            cw_en,
  input logic [IW-1:0]   cw_idx,
  input logic [DW-1:0]   cw_xdata,
  input logic [IW-1:0]   rd0_idx,
  input logic [DW-1:0]   rd0_xdata,
  input logic [DW-1:0]   rd0_ydata,
  input logic            bus_we,
  input logic [IW-1:0]   bus_idx,
  input logic [2*DW-1:0] bus_wdata,
  input logic [2*DW-1:0] bus_rdata
);

  // R2
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (simd_on == $past(mode_simd_d)) && (alt_bank_on == $past(mode_alt_d)));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(simd_on) && $stable(alt_bank_on));

  // R5
  y_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !simd_on |-> (rd0_ydata == '0) && (bus_rdata[2*DW-1:DW] == '0));

  // R3
  cw_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && !mode_we && !(bus_we && bus_idx == cw_idx) && rd0_idx == cw_idx)
    |=> (rd0_idx != $past(rd0_idx)) || (rd0_xdata == $past(cw_xdata)));

  // R8
  bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && bus_we && bus_idx == cw_idx && !mode_we && rd0_idx == cw_idx)
    |=> (rd0_idx != $past(rd0_idx)) || (rd0_xdata == $past(bus_wdata[DW-1:0])));

  // R9
  quiet_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cw_en && !bus_we && !mode_we)
    |=> (rd0_idx != $past(rd0_idx)) || $stable(rd0_xdata));

endmodule

bind dual_lane_rf dual_lane_rf_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_we     (mode_we),
  .mode_simd_d (mode_simd_d),
  .mode_alt_d  (mode_alt_d),
  .simd_on     (simd_on),
  .alt_bank_on (alt_bank_on),
  .cw_en       (cw_en),
  .cw_idx      (cw_idx),
  .cw_xdata    (cw_xdata),
  .rd0_idx     (rd0_idx),
  .rd0_xdata   (rd0_xdata),
  .rd0_ydata   (rd0_ydata),
  .bus_we      (bus_we),
  .bus_idx     (bus_idx),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata)
);

// File: tb/dual_lane_rf_test.sv
module dual_lane_rf_test;

  localparam int DW   = 40;
  localparam int NREG = 16;
  localparam int IW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode_we = 1'b0, mode_simd_d = 1'b0, mode_alt_d = 1'b0;
  logic            simd_on, alt_bank_on;
  logic            cw_en = 1'b0;
  logic [IW-1:0]   cw_idx = '0;
  logic [DW-1:0]   cw_xdata = '0, cw_ydata = '0;
  logic [IW-1:0]   rd0_idx = '0, rd1_idx = '0;
  logic [DW-1:0]   rd0_xdata, rd0_ydata, rd1_xdata, rd1_ydata;
  logic            bus_we = 1'b0;
  logic [IW-1:0]   bus_idx = '0;
  logic [2*DW-1:0] bus_wdata = '0;
  logic [2*DW-1:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural model: [bank][reg]
  logic [DW-1:0] mx [2][NREG];
  logic [DW-1:0] my [2][NREG];
  int m_simd = 0;
  int m_bank = 0;

  always #5 clk = ~clk;

  dual_lane_rf uut (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_simd_d(mode_simd_d), .mode_alt_d(mode_alt_d),
    .simd_on(simd_on), .alt_bank_on(alt_bank_on),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_xdata(cw_xdata), .cw_ydata(cw_ydata),
    .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
    .rd0_xdata(rd0_xdata), .rd0_ydata(rd0_ydata),
    .rd1_xdata(rd1_xdata), .rd1_ydata(rd1_ydata),
    .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(string tag, string what, logic [2*DW-1:0] act, logic [2*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [DW-1:0] ey0, ey1, eyb;
    ey0 = (m_simd != 0) ? my[m_bank][rd0_idx] : '0;
    ey1 = (m_simd != 0) ? my[m_bank][rd1_idx] : '0;
    eyb = (m_simd != 0) ? my[m_bank][bus_idx] : '0;
    chk(tag, "simd_on",     2*DW'(simd_on),     2*DW'(m_simd != 0));
    chk(tag, "alt_bank_on", 2*DW'(alt_bank_on), 2*DW'(m_bank != 0));
    chk(tag, "rd0_x", 2*DW'(rd0_xdata), 2*DW'(mx[m_bank][rd0_idx]));
    chk(tag, "rd1_x", 2*DW'(rd1_xdata), 2*DW'(mx[m_bank][rd1_idx]));
    chk(tag, "rd0_y", 2*DW'(rd0_ydata), 2*DW'(ey0));
    chk(tag, "rd1_y", 2*DW'(rd1_ydata), 2*DW'(ey1));
    chk(tag, "bus_rdata", bus_rdata, {eyb, mx[m_bank][bus_idx]});
  endtask

  task automatic model_edge();
    if (cw_en) begin
      mx[m_bank][cw_idx] = cw_xdata;
      if (m_simd != 0) my[m_bank][cw_idx] = cw_ydata;
    end
    if (bus_we) begin
      mx[m_bank][bus_idx] = bus_wdata[DW-1:0];
      if (m_simd != 0) my[m_bank][bus_idx] = bus_wdata[2*DW-1:DW];
    end
    if (mode_we) begin
      m_simd = mode_simd_d ? 1 : 0;
      m_bank = mode_alt_d ? 1 : 0;
    end
  endtask

  // inputs are set right after a falling edge; compare, clock, update model
  task automatic cyc(string tag);
    #1 compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    mode_we = 1'b0; cw_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic set_mode(logic s, logic a);
    mode_we = 1'b1; mode_simd_d = s; mode_alt_d = a;
  endtask

  task automatic cwr(logic [IW-1:0] i, logic [DW-1:0] x, logic [DW-1:0] y);
    cw_en = 1'b1; cw_idx = i; cw_xdata = x; cw_ydata = y;
  endtask

  task automatic bwr(logic [IW-1:0] i, logic [2*DW-1:0] d);
    bus_we = 1'b1; bus_idx = i; bus_wdata = d;
  endtask

  task automatic rd(logic [IW-1:0] a, logic [IW-1:0] b, logic [IW-1:0] c);
    rd0_idx = a; rd1_idx = b; bus_idx = c;
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < NREG; r++) begin
        mx[b][r] = '0; my[b][r] = '0;
      end
    // R1: reset state, while held and after release
    @(negedge clk);
    rd(3, 9, 15);
    #1 compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1");

    // R5 + R4: non-SIMD write to reg 3, Y data must be dropped; same-cycle read is old
    cwr(3, 40'h11_1111_1111, 40'hEE_EEEE_EEEE); rd(3, 3, 3);
    cyc("R4");
    idle();
    cyc("R3");
    // R7: non-SIMD bus write, only the low half lands
    bwr(5, {40'hAB_CDEF_0123, 40'h55_0000_0005}); rd(5, 3, 5);
    cyc("R7");
    idle();
    cyc("R5");

    // R2: enable SIMD, write in the same cycle still runs without lane Y
    set_mode(1'b1, 1'b0); cwr(6, 40'h66, 40'h99); rd(6, 3, 6);
    cyc("R2");
    idle();
    cyc("R5");
    // R6: SIMD compute write hits both lanes
    cwr(7, 40'h70_0000_0007, 40'h7F_FFFF_FFF7); rd(7, 6, 7);
    cyc("R6");
    idle();
    cyc("R6");
    // R7: SIMD bus write of a pair
    bwr(8, {40'h88_8888_0001, 40'h80_0000_0008}); rd(8, 7, 8);
    cyc("R7");
    idle();
    cyc("R7");

    // R8: same register from both ports, bus wins in each lane
    cwr(9, 40'h01, 40'h02); bwr(9, {40'hB2, 40'hB1}); rd(9, 9, 9);
    cyc("R8");
    idle();
    cyc("R8");
    // R11: different registers from both ports
    cwr(10, 40'hA0, 40'hA1); bwr(11, {40'hB1B, 40'hB0B}); rd(10, 11, 11);
    cyc("R11");
    idle();
    rd(10, 11, 10);
    cyc("R11");

    // R9/R10: swap to secondary bank, write there, swap back
    set_mode(1'b1, 1'b1); cwr(7, 40'hDE, 40'hAD); rd(7, 8, 7);
    cyc("R10");
    idle();
    cyc("R10");
    cwr(7, 40'h5EC0, 40'h5EC1); rd(7, 8, 7);
    cyc("R9");
    idle();
    cyc("R9");
    set_mode(1'b1, 1'b0);
    cyc("R9");
    idle();
    cyc("R9");
    // R5: leave SIMD, Y lane reads zero and writes drop
    set_mode(1'b0, 1'b0);
    cyc("R5");
    idle();
    cwr(7, 40'h1, 40'hFF); rd(7, 7, 7);
    cyc("R5");
    idle(); set_mode(1'b1, 1'b0);
    cyc("R5");
    idle();
    cyc("R5");

    // random overlap of all functions on a narrow index range
    for (int n = 0; n < 600; n++) begin
      mode_we     = ($urandom_range(0, 7) == 0);
      mode_simd_d = 1'($urandom_range(0, 1));
      mode_alt_d  = 1'($urandom_range(0, 1));
      cw_en       = 1'($urandom_range(0, 1));
      cw_idx      = IW'($urandom_range(0, 3));
      cw_xdata    = {8'($urandom), 32'($urandom)};
      cw_ydata    = {8'($urandom), 32'($urandom)};
      bus_we      = 1'($urandom_range(0, 1));
      bus_idx     = IW'($urandom_range(0, 3));
      bus_wdata   = {16'($urandom), 32'($urandom), 32'($urandom)};
      rd0_idx     = IW'($urandom_range(0, 3));
      rd1_idx     = IW'($urandom_range(0, 15));
      cyc("R3");
    end
    idle();
    cyc("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule